// File: doc/BRIEF.md
# I2C Master Serial Clock Generator

This block produces the serial clock of an I2C master from the local clock. A small configuration bank holds the local clock rate in whole MHz, a bus speed class (standard or fast), a fast-class duty selector, a divider and a rise allowance. From these it works out how many local clocks the line spends low and how many it spends released. It drives the open-drain line through an active-high pull-down enable and reads the wired line back. This lets a slave stretch the clock by holding the line low after the master lets go.

The byte engine that sequences SDA receives two single-cycle strobes. One marks each falling edge the master makes. The other marks the start of each counted high phase. All configuration is loaded with a write strobe while the generator is stopped. A configuration outside the legal ranges drops the valid flag and leaves the line released. The line-sense input is assumed to be already synchronised to `clk`.

Top module: `scl_clock_gen`

## Requirements
- R1: The MHz field is legal only from 2 to 50 inclusive. Outside that range `cfg_ok` is 0, `scl_oe` stays 0 and no tick is issued even with `enable` high.
- R2: The divider must be at least 4 in standard class (`cfg_fast`=0) and at least 1 in fast class. A smaller divider gives the same result as R1.
- R3: In standard class the low phase and the released phase each last `cfg_div` clocks when the line rises at once. `cfg_duty_16_9` has no effect in this class.
- R4: In fast class with `cfg_duty_16_9`=0, the low phase lasts 2×`cfg_div` clocks and the released phase lasts 1×`cfg_div` clocks.
- R5: In fast class with `cfg_duty_16_9`=1, the low phase lasts 16×`cfg_div` clocks and the released phase lasts 9×`cfg_div` clocks.
- R6: Let n be the number of clocks from release up to and including the first clock in which the line is sampled high. The counted high phase then lasts H − min(n, `cfg_rise`) clocks, but never less than 1. H is the nominal high length. With `cfg_rise`=0 nothing is credited, so a line that rises at once stays released for H+1 clocks.
- R7: While the master has released the line and the line reads low, `scl_oe` stays 0 however long that lasts. There is no timeout.
- R8: Configuration is captured on `cfg_we` only while `enable` is 0. A write while enabled changes neither the timing nor `cfg_ok`.
- R9: `tick_fall` is high for one clock, in the first clock in which `scl_oe` is 1. `tick_rise` is high for one clock, in the clock after the released line is first sampled high.
- R10: After reset `scl_oe`, both ticks and `cfg_ok` are 0, because every configuration field resets to 0.
- R11: With a legal configuration, `scl_oe` rises in the clock after `enable` rises. Dropping `enable` releases the line in the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low reset |
| enable | input | 1 | Runs the generator; configuration loads only while low |
| cfg_we | input | 1 | Configuration load strobe |
| cfg_mhz | input | 6 | Local clock rate in whole MHz |
| cfg_fast | input | 1 | 0 = standard class, 1 = fast class |
| cfg_duty_16_9 | input | 1 | Fast class only: 0 = 2:1 low/high, 1 = 16:9 |
| cfg_div | input | 12 | Phase divider |
| cfg_rise | input | 6 | Rise allowance in clocks credited against the high phase |
| scl_in | input | 1 | Sensed level of the wired clock line |
| scl_oe | output | 1 | Pull the line low when 1 |
| tick_fall | output | 1 | One-clock strobe at each driven falling edge |
| tick_rise | output | 1 | One-clock strobe at the start of each counted high phase |
| cfg_ok | output | 1 | Captured configuration is legal |

## Verification
The bench targets the edges of the legal ranges (2 and 50 MHz, a standard divider of 4 against 3, a fast divider of 1 against 0). A design with an off-by-one limit would either run an illegal setting or refuse a legal one. It checks all three ratio schemes, including the 16:9 scheme in standard class, where a design that did not ignore the duty bit would stretch both phases. It stretches the clock for 1, 2, 6 and 40 clocks. A design that did not cap the rise credit would shorten the high phase too much, and one with a hidden timeout would pull the line low mid-stretch. It also writes configuration while running; a design that accepted that write would change the period in flight.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_WAIT = 2'd2,
    PH_HIGH = 2'd3
  } phase_e;

endpackage

// File: rtl/scl_cfg_bank.sv
module scl_cfg_bank #(
  parameter int DIV_W       = 12,
  parameter int MHZ_W       = 6,
  parameter int RISE_W      = 6,
  parameter int MHZ_MIN     = 2,
  parameter int MHZ_MAX     = 50,
  parameter int STD_DIV_MIN = 4,
  parameter int FST_DIV_MIN = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  enable,
  input  logic                  cfg_we,
  input  logic [MHZ_W-1:0]      cfg_mhz,
  input  logic                  cfg_fast,
  input  logic                  cfg_duty_16_9,
  input  logic [DIV_W-1:0]      cfg_div,
  input  logic [RISE_W-1:0]     cfg_rise,
  output logic [DIV_W+3:0]      low_len,
  output logic [DIV_W+3:0]      high_len,
  output logic [RISE_W-1:0]     rise_lim,
  output logic                  cfg_ok
);
  localparam int CNT_W = DIV_W + 4;

  logic [MHZ_W-1:0]  r_mhz;
  logic              r_fast;
  logic              r_duty;
  logic [DIV_W-1:0]  r_div;
  logic [RISE_W-1:0] r_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_mhz  <= '0;
      r_fast <= 1'b0;
      r_duty <= 1'b0;
      r_div  <= '0;
      r_rise <= '0;
    end else if (cfg_we && !enable) begin
      r_mhz  <= cfg_mhz;
      r_fast <= cfg_fast;
      r_duty <= cfg_duty_16_9;
      r_div  <= cfg_div;
      r_rise <= cfg_rise;
    end
  end

  logic             mhz_ok, div_ok;
  logic [CNT_W-1:0] div_x;

  always_comb begin
    mhz_ok = (r_mhz >= MHZ_W'(MHZ_MIN)) && (r_mhz <= MHZ_W'(MHZ_MAX));
    div_ok = r_fast ? (r_div >= DIV_W'(FST_DIV_MIN))
                    : (r_div >= DIV_W'(STD_DIV_MIN));
    cfg_ok = mhz_ok && div_ok;
    div_x  = CNT_W'(r_div);
    rise_lim = r_rise;
    if (!r_fast) begin
      low_len  = div_x;
      high_len = div_x;
    end else if (r_duty) begin
      low_len  = div_x << 4;
      high_len = (div_x << 3) + div_x;
    end else begin
      low_len  = div_x << 1;
      high_len = div_x;
    end
  end

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
  import scl_gen_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int RISE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              scl_in,
  input  logic [CNT_W-1:0]  low_len,
  input  logic [CNT_W-1:0]  high_len,
  input  logic [RISE_W-1:0] rise_lim,
  output phase_e            phase,
  output logic              scl_oe,
  output logic              tick_fall,
  output logic              tick_rise
);
  localparam logic [RISE_W-1:0] WAIT_SAT = '1;

  phase_e            ph;
  logic [CNT_W-1:0]  cnt;
  logic [RISE_W-1:0] wcnt;
  logic [RISE_W:0]   seen, credit;
  logic [CNT_W-1:0]  credit_x, hload;

  always_comb begin
    seen     = {1'b0, wcnt} + 1'b1;
    credit   = (seen < {1'b0, rise_lim}) ? seen : {1'b0, rise_lim};
    credit_x = CNT_W'(credit);
    hload    = (high_len > credit_x) ? (high_len - credit_x - 1'b1) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph        <= PH_IDLE;
      cnt       <= '0;
      wcnt      <= '0;
      tick_fall <= 1'b0;
      tick_rise <= 1'b0;
    end else begin
      tick_fall <= 1'b0;
      tick_rise <= 1'b0;
      if (!run) begin
        ph <= PH_IDLE;
      end else begin
        case (ph)
          PH_IDLE: begin
            ph        <= PH_LOW;
            cnt       <= low_len - 1'b1;
            tick_fall <= 1'b1;
          end
          PH_LOW: begin
            if (cnt == '0) begin
              ph   <= PH_WAIT;
              wcnt <= '0;
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
          PH_WAIT: begin
            if (scl_in) begin
              ph        <= PH_HIGH;
              cnt       <= hload;
              tick_rise <= 1'b1;
            end else if (wcnt != WAIT_SAT) begin
              wcnt <= wcnt + 1'b1;
            end
          end
          default: begin
            if (cnt == '0) begin
              ph        <= PH_LOW;
              cnt       <= low_len - 1'b1;
              tick_fall <= 1'b1;
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
        endcase
      end
    end
  end

  assign phase  = ph;
  assign scl_oe = (ph == PH_LOW);

endmodule

// File: rtl/scl_clock_gen.sv
module scl_clock_gen
  import scl_gen_pkg::*;
#(
  parameter int DIV_W  = 12,
  parameter int MHZ_W  = 6,
  parameter int RISE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              cfg_we,
  input  logic [MHZ_W-1:0]  cfg_mhz,
  input  logic              cfg_fast,
  input  logic              cfg_duty_16_9,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [RISE_W-1:0] cfg_rise,
  input  logic              scl_in,
  output logic              scl_oe,
  output logic              tick_fall,
  output logic              tick_rise,
  output logic              cfg_ok
);
  localparam int CNT_W = DIV_W + 4;

  logic [CNT_W-1:0]  low_len, high_len;
  logic [RISE_W-1:0] rise_lim;
  logic              run;
  phase_e            phase;

  scl_cfg_bank #(
    .DIV_W (DIV_W),
    .MHZ_W (MHZ_W),
    .RISE_W(RISE_W)
  ) u_cfg (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .cfg_we       (cfg_we),
    .cfg_mhz      (cfg_mhz),
    .cfg_fast     (cfg_fast),
    .cfg_duty_16_9(cfg_duty_16_9),
    .cfg_div      (cfg_div),
    .cfg_rise     (cfg_rise),
    .low_len      (low_len),
    .high_len     (high_len),
    .rise_lim     (rise_lim),
    .cfg_ok       (cfg_ok)
  );

  assign run = enable && cfg_ok;

  scl_phase_fsm #(
    .CNT_W (CNT_W),
    .RISE_W(RISE_W)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .scl_in   (scl_in),
    .low_len  (low_len),
    .high_len (high_len),
    .rise_lim (rise_lim),
    .phase    (phase),
    .scl_oe   (scl_oe),
    .tick_fall(tick_fall),
    .tick_rise(tick_rise)
  );

endmodule

// File: rtl/scl_gen_checker.sv
module scl_gen_checker
  import scl_gen_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input logic   enable,
  input logic   run,
  input logic   cfg_ok,
  input logic   scl_in,
  input logic   scl_oe,
  input logic   tick_fall,
  input logic   tick_rise,
  input phase_e ph
);

  a_r1_illegal_released: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_ok |-> (!scl_oe && !tick_fall && !tick_rise));

  a_r7_stretch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (run && ph == PH_WAIT && !scl_in) |=> (!scl_oe && ph == PH_WAIT));

  a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable)) |-> $stable(cfg_ok));

  a_r9_fall_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe) |-> tick_fall);

  a_r9_fall_tick_driven: assert property (@(posedge clk) disable iff (!rst_n)
    tick_fall |-> scl_oe);

  a_r9_rise_tick: assert property (@(posedge clk) disable iff (!rst_n)
    tick_rise |-> (!scl_oe && $past(scl_in)));

  a_r9_ticks_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick_fall && tick_rise));

  a_r11_disable_release: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !scl_oe);

endmodule

bind scl_clock_gen scl_gen_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .enable   (enable),
  .run      (run),
  .cfg_ok   (cfg_ok),
  .scl_in   (scl_in),
  .scl_oe   (scl_oe),
  .tick_fall(tick_fall),
  .tick_rise(tick_rise),
  .ph       (phase)
);

// File: tb/scl_clock_gen_test.sv
`timescale 1ns/1ps
module scl_clock_gen_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_mhz = '0;
  logic        cfg_fast = 1'b0;
  logic        cfg_duty_16_9 = 1'b0;
  logic [11:0] cfg_div = '0;
  logic [5:0]  cfg_rise = '0;
  logic        hold = 1'b0;
  logic        scl_line;
  logic        scl_oe, tick_fall, tick_rise, cfg_ok;

  int nchk = 0;
  int nfail = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  assign scl_line = ~(scl_oe | hold);

  scl_clock_gen uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .cfg_we       (cfg_we),
    .cfg_mhz      (cfg_mhz),
    .cfg_fast     (cfg_fast),
    .cfg_duty_16_9(cfg_duty_16_9),
    .cfg_div      (cfg_div),
    .cfg_rise     (cfg_rise),
    .scl_in       (scl_line),
    .scl_oe       (scl_oe),
    .tick_fall    (tick_fall),
    .tick_rise    (tick_rise),
    .cfg_ok       (cfg_ok)
  );

  // fast, duty, div, mhz, rise, expected low, expected released-high, requirement
  localparam int    NV = 6;
  localparam int    VF  [NV] = '{0, 0, 1, 1, 1, 1};
  localparam int    VD  [NV] = '{0, 1, 0, 1, 1, 0};
  localparam int    VDV [NV] = '{5, 4, 3, 1, 2, 2};
  localparam int    VMZ [NV] = '{8, 2, 50, 36, 20, 10};
  localparam int    VRS [NV] = '{9, 9, 16, 11, 7, 0};
  localparam int    VLO [NV] = '{5, 4, 6, 16, 32, 4};
  localparam int    VHI [NV] = '{5, 4, 3, 9, 18, 3};
  localparam string VRQ [NV] = '{"R3", "R3", "R4", "R5", "R5", "R6"};

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load(input int f, input int d, input int dv, input int mz, input int rs);
    @(negedge clk);
    enable        = 1'b0;
    cfg_fast      = f[0];
    cfg_duty_16_9 = d[0];
    cfg_div       = dv[11:0];
    cfg_mhz       = mz[5:0];
    cfg_rise      = rs[5:0];
    cfg_we        = 1'b1;
    @(negedge clk);
    cfg_we        = 1'b0;
  endtask

  task automatic meas(output int lo, output int hi, output int tf_first, output int tr_n);
    @(negedge clk);
    while (scl_oe) @(negedge clk);
    while (!scl_oe) @(negedge clk);
    tf_first = tick_fall;
    lo = 0;
    tr_n = 0;
    while (scl_oe) begin
      lo++;
      @(negedge clk);
    end
    hi = 0;
    while (!scl_oe) begin
      if (scl_line) hi++;
      if (tick_rise) tr_n++;
      @(negedge clk);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        nfail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
      end
    end
  end

  initial begin
    int lo, hi, tf, tr;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", {29'd0, scl_oe, tick_fall, tick_rise}, 0);
    chk("R10", int'(cfg_ok), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", int'(scl_oe), 0);

    // Table of ratio schemes
    for (int i = 0; i < NV; i++) begin
      load(VF[i], VD[i], VDV[i], VMZ[i], VRS[i]);
      chk(VRQ[i], int'(cfg_ok), 1);
      enable = 1'b1;
      meas(lo, hi, tf, tr);
      meas(lo, hi, tf, tr);
      chk(VRQ[i], lo, VLO[i]);
      chk(VRQ[i], hi, VHI[i]);
      chk("R9", tf, 1);
      chk("R9", tr, 1);
    end

    // R11: start latency and stop latency
    load(0, 0, 6, 12, 4);
    enable = 1'b1;
    @(negedge clk);
    chk("R11", int'(scl_oe), 1);
    chk("R9", int'(tick_fall), 1);
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    chk("R11", int'(scl_oe), 0);

    // R8: write while enabled is ignored
    load(0, 0, 5, 8, 9);
    enable = 1'b1;
    @(negedge clk);
    cfg_mhz = 6'd0;
    cfg_div = 12'd20;
    cfg_we  = 1'b1;
    @(negedge clk);
    cfg_we  = 1'b0;
    @(negedge clk);
    chk("R8", int'(cfg_ok), 1);
    meas(lo, hi, tf, tr);
    meas(lo, hi, tf, tr);
    chk("R8", lo, 5);
    chk("R8", hi, 5);
    // once stopped, the same write is taken: MHz 0 is illegal (R1)
    enable = 1'b0;
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    @(negedge clk);
    chk("R1", int'(cfg_ok), 0);

    // R1 / R2: illegal settings keep the line released
    for (int k = 0; k < 4; k++) begin
      int seen;
      case (k)
        0: load(0, 0, 10, 1, 3);
        1: load(0, 0, 10, 51, 3);
        2: load(0, 0, 3, 8, 3);
        default: load(1, 0, 0, 8, 3);
      endcase
      enable = 1'b1;
      seen = 0;
      for (int c = 0; c < 40; c++) begin
        @(negedge clk);
        if (scl_oe || tick_fall || tick_rise) seen++;
      end
      chk(k < 2 ? "R1" : "R2", int'(cfg_ok), 0);
      chk(k < 2 ? "R1" : "R2", seen, 0);
    end

    // R6 / R7: clock stretching with rise credit, nominal high 10, allowance 3
    load(0, 0, 10, 8, 3);
    enable = 1'b1;
    meas(lo, hi, tf, tr);
    for (int k = 0; k < 4; k++) begin
      int s, sl, saw, trf, exp_hi;
      case (k)
        0: sl = 1;
        1: sl = 2;
        2: sl = 6;
        default: sl = 40;
      endcase
      exp_hi = 10 - ((sl < 3) ? sl : 3);
      @(negedge clk);
      while (!scl_oe) @(negedge clk);
      #0.5 hold = 1'b1;
      while (scl_oe) @(negedge clk);
      s = 1;
      saw = 0;
      while (s < sl) begin
        @(negedge clk);
        if (scl_oe) saw++;
        s++;
      end
      #0.5 hold = 1'b0;
      @(negedge clk);
      trf = tick_rise;
      hi = 0;
      while (!scl_oe) begin
        if (scl_line) hi++;
        @(negedge clk);
      end
      chk("R6", hi, exp_hi);
      chk("R7", saw, 0);
      chk("R9", trf, 1);
    end

    enable = 1'b0;
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule